// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block holds the two program stack pointers of a small processor core. One pointer serves supervisor code and is also the default when no protection is used. The other pointer serves user code. A user-mode flag inside a status value chooses which pointer each stack access uses. A simple instruction decoder drives one-cycle strobes for push, pop, pop-and-return, jump-to-user, trap entry, trap return and a privileged status load. The block then presents the stack address for the access, a write enable for pushed data, the current mode and the status value.

Pointers move in word steps. A push decrements the selected pointer before the access, and a pop or pop-and-return increments it after the access. A trap always moves execution onto the supervisor pointer. Trap return restores the status value that was saved when the trap was taken. While in user mode, a status load is refused and a privilege-violation pulse is raised. Instruction fetch, memory, the register file and trap vectoring sit outside the block.

Top module: `spbank_unit`

## Requirements
- R1: After reset, the user-mode flag is clear, the status value is zero, both pointers hold TOS_INIT (default 0xFF00), stk_addr_o shows TOS_INIT, and stk_we_o and priv_viol_o are low.
- R2: When the user-mode flag is clear, every stack operation uses the supervisor pointer and leaves the user pointer unchanged.
- R3: When the user-mode flag is set, every stack operation uses the user pointer and leaves the supervisor pointer unchanged.
- R4: On a push, stk_addr_o equals the selected pointer minus 2 and stk_we_o is high in the same cycle, and the pointer holds that value from the next cycle on.
- R5: On a pop or pop-and-return, stk_addr_o equals the selected pointer, stk_we_o is low, and the pointer is 2 higher from the next cycle on.
- R6: Only the jump-to-user strobe sets the user-mode flag, which is bit U_BIT (default 7) of the status value. It takes effect in the next cycle. A status load in supervisor mode writes every other bit but keeps bit U_BIT.
- R7: Trap entry copies the status value into a one-deep save register and clears the user-mode flag from the next cycle on. A stack operation in the same cycle uses the supervisor pointer.
- R8: Trap return loads the status value, including the user-mode flag, from the save register.
- R9: A status load while the user-mode flag is set leaves the status value unchanged, and priv_viol_o is high for exactly the following cycle.
- R10: With no push, pop or pop-and-return strobe, neither pointer changes and stk_addr_o shows the active pointer.
- R11: Mode events rank as trap entry, then trap return, then jump-to-user, then status load, and only the highest one present acts. Stack operations rank push before pop before pop-and-return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Push strobe |
| pop_i | input | 1 | Pop strobe |
| pop_ret_i | input | 1 | Pop-and-return strobe |
| to_user_i | input | 1 | Jump-to-user strobe |
| trap_enter_i | input | 1 | Trap entry strobe |
| trap_ret_i | input | 1 | Trap return strobe |
| stat_ld_i | input | 1 | Privileged status load request |
| stat_ld_data_i | input | STAT_W | Data for the status load |
| stk_addr_o | output | PTR_W | Stack address for the current access |
| stk_we_o | output | 1 | Write enable for pushed data |
| user_mode_o | output | 1 | Current user-mode flag |
| stat_o | output | STAT_W | Current status value |
| priv_viol_o | output | 1 | Privilege-violation pulse |

## Verification
The bench targets the cycle where a trap entry and a push land together. A design that sampled the old mode would push onto the user pointer and corrupt the user stack. It also drives status loads in both modes. A design that let the load through in user mode would drop to supervisor without a trap, and one that let a supervisor load set the flag would open a second path into user mode. The bench runs nested traps, trap returns and simultaneous strobes as well. These catch a save register that is not restored, a lost flag, or a priority order that differs from R11, each of which shows up as a wrong mode or a wrong stack address.

// File: rtl/spbank_pkg.sv
package spbank_pkg;

   localparam int unsigned NBANK    = 2;
   localparam int unsigned BANK_SUP = 0;
   localparam int unsigned BANK_USR = 1;

   typedef enum logic [1:0] {
      SOP_NONE = 2'd0,
      SOP_PUSH = 2'd1,
      SOP_POP  = 2'd2
   } stk_op_e;

   typedef enum logic [2:0] {
      EV_NONE     = 3'd0,
      EV_TRAP_IN  = 3'd1,
      EV_TRAP_OUT = 3'd2,
      EV_TO_USER  = 3'd3,
      EV_LOAD     = 3'd4
   } stat_ev_e;

endpackage

// File: rtl/spbank_decode.sv
module spbank_decode
   import spbank_pkg::*;
(
   input  logic     push_i,
   input  logic     pop_i,
   input  logic     pop_ret_i,
   input  logic     to_user_i,
   input  logic     trap_enter_i,
   input  logic     trap_ret_i,
   input  logic     stat_ld_i,
   input  logic     user_q_i,
   output stk_op_e  op_o,
   output logic     bank_sel_o,
   output stat_ev_e ev_o,
   output logic     refuse_o
);

   // stack operation: push ranks above either pop flavour
   always_comb begin
      if (push_i)                 op_o = SOP_PUSH;
      else if (pop_i | pop_ret_i) op_o = SOP_POP;
      else                        op_o = SOP_NONE;
   end

   // a trap in the same cycle forces the supervisor bank
   always_comb begin
      if (trap_enter_i) bank_sel_o = 1'b0;
      else              bank_sel_o = user_q_i;
   end

   // mode/status events, highest priority first
   always_comb begin
      if (trap_enter_i)    ev_o = EV_TRAP_IN;
      else if (trap_ret_i) ev_o = EV_TRAP_OUT;
      else if (to_user_i)  ev_o = EV_TO_USER;
      else if (stat_ld_i)  ev_o = EV_LOAD;
      else                 ev_o = EV_NONE;
   end

   assign refuse_o = (ev_o == EV_LOAD) && user_q_i;

endmodule

// File: rtl/spbank_ptr.sv
module spbank_ptr
   import spbank_pkg::*;
#(
   parameter int unsigned      PTR_W    = 16,
   parameter int unsigned      STEP     = 2,
   parameter logic [PTR_W-1:0] TOS_INIT = 16'hFF00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  stk_op_e          op_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic [PTR_W-1:0] addr_o
);

   localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_dec;
   logic [PTR_W-1:0] ptr_inc;

   assign ptr_dec = ptr_q - STEP_V;
   assign ptr_inc = ptr_q + STEP_V;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q <= TOS_INIT;
      end else if (en_i) begin
         case (op_i)
            SOP_PUSH: ptr_q <= ptr_dec;
            SOP_POP:  ptr_q <= ptr_inc;
            default:  ptr_q <= ptr_q;
         endcase
      end
   end

   // push accesses the pre-decremented word, pop the current one
   assign addr_o = (en_i && op_i == SOP_PUSH) ? ptr_dec : ptr_q;
   assign ptr_o  = ptr_q;

   assert_idle_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i || op_i == SOP_NONE) |=> $stable(ptr_q));

   assert_push_step_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == SOP_PUSH) |=> ptr_q == $past(ptr_q) - STEP_V);

   assert_pop_step_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && op_i == SOP_POP) |=> ptr_q == $past(ptr_q) + STEP_V);

endmodule

// File: rtl/spbank_status.sv
module spbank_status
   import spbank_pkg::*;
#(
   parameter int unsigned STAT_W = 8,
   parameter int unsigned U_BIT  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  stat_ev_e          ev_i,
   input  logic              refuse_i,
   input  logic [STAT_W-1:0] ld_data_i,
   output logic [STAT_W-1:0] stat_o,
   output logic              user_o,
   output logic              viol_o
);

   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] save_q;
   logic [STAT_W-1:0] stat_d;
   logic [STAT_W-1:0] save_d;
   logic              viol_q;

   always_comb begin
      stat_d = stat_q;
      save_d = save_q;
      case (ev_i)
         EV_TRAP_IN: begin
            save_d        = stat_q;
            stat_d[U_BIT] = 1'b0;
         end
         EV_TRAP_OUT: stat_d = save_q;
         EV_TO_USER:  stat_d[U_BIT] = 1'b1;
         EV_LOAD: begin
            if (!refuse_i) begin
               stat_d        = ld_data_i;
               stat_d[U_BIT] = stat_q[U_BIT];
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         save_q <= '0;
         viol_q <= 1'b0;
      end else begin
         stat_q <= stat_d;
         save_q <= save_d;
         viol_q <= refuse_i;
      end
   end

   assign stat_o = stat_q;
   assign user_o = stat_q[U_BIT];
   assign viol_o = viol_q;

   assert_user_entry_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(user_o) |-> ($past(ev_i) == EV_TO_USER || $past(ev_i) == EV_TRAP_OUT));

   assert_trap_clears_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_TRAP_IN) |=> !user_o);

   assert_trap_restore_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i == EV_TRAP_OUT) |=> stat_o == $past(save_q));

   assert_refused_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      refuse_i |=> ($stable(stat_o) && viol_o));

   assert_viol_cause_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> $past(ev_i == EV_LOAD && user_o));

endmodule

// File: rtl/spbank_unit.sv
module spbank_unit
   import spbank_pkg::*;
#(
   parameter int unsigned      PTR_W    = 16,
   parameter int unsigned      STEP     = 2,
   parameter logic [PTR_W-1:0] TOS_INIT = 16'hFF00,
   parameter int unsigned      STAT_W   = 8,
   parameter int unsigned      U_BIT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              pop_ret_i,
   input  logic              to_user_i,
   input  logic              trap_enter_i,
   input  logic              trap_ret_i,
   input  logic              stat_ld_i,
   input  logic [STAT_W-1:0] stat_ld_data_i,
   output logic [PTR_W-1:0]  stk_addr_o,
   output logic              stk_we_o,
   output logic              user_mode_o,
   output logic [STAT_W-1:0] stat_o,
   output logic              priv_viol_o
);

   localparam logic [PTR_W-1:0] STEP_V = PTR_W'(STEP);

   // elaboration-time parameter checks
   generate
      if (PTR_W < 2)                  $error("PTR_W must be at least 2");
      if (STEP == 0)                  $error("STEP must be nonzero");
      if ((TOS_INIT % STEP) != 0)     $error("TOS_INIT must be STEP aligned");
      if (U_BIT >= STAT_W)            $error("U_BIT must lie inside the status value");
   endgenerate

   stk_op_e          op;
   stat_ev_e         ev;
   logic             bank_sel;
   logic             refuse;
   logic             user_q;
   logic [PTR_W-1:0] ptr_q  [NBANK];
   logic [PTR_W-1:0] addr_b [NBANK];

   spbank_decode u_decode (
      .push_i       (push_i),
      .pop_i        (pop_i),
      .pop_ret_i    (pop_ret_i),
      .to_user_i    (to_user_i),
      .trap_enter_i (trap_enter_i),
      .trap_ret_i   (trap_ret_i),
      .stat_ld_i    (stat_ld_i),
      .user_q_i     (user_q),
      .op_o         (op),
      .bank_sel_o   (bank_sel),
      .ev_o         (ev),
      .refuse_o     (refuse)
   );

   spbank_status #(
      .STAT_W (STAT_W),
      .U_BIT  (U_BIT)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .ev_i      (ev),
      .refuse_i  (refuse),
      .ld_data_i (stat_ld_data_i),
      .stat_o    (stat_o),
      .user_o    (user_q),
      .viol_o    (priv_viol_o)
   );

   generate
      for (genvar g = 0; g < NBANK; g++) begin : g_bank
         logic bank_en;
         assign bank_en = (bank_sel == g[0]);
         spbank_ptr #(
            .PTR_W    (PTR_W),
            .STEP     (STEP),
            .TOS_INIT (TOS_INIT)
         ) u_ptr (
            .clk    (clk),
            .rst_n  (rst_n),
            .en_i   (bank_en),
            .op_i   (op),
            .ptr_o  (ptr_q[g]),
            .addr_o (addr_b[g])
         );
      end
   endgenerate

   assign stk_addr_o  = bank_sel ? addr_b[BANK_USR] : addr_b[BANK_SUP];
   assign stk_we_o    = (op == SOP_PUSH);
   assign user_mode_o = user_q;

   assert_sup_bank_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && (trap_enter_i || !user_mode_o))
         |=> (ptr_q[BANK_SUP] == $past(ptr_q[BANK_SUP]) - STEP_V) && $stable(ptr_q[BANK_USR]));

   assert_usr_bank_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !trap_enter_i && user_mode_o)
         |=> (ptr_q[BANK_USR] == $past(ptr_q[BANK_USR]) - STEP_V) && $stable(ptr_q[BANK_SUP]));

   assert_push_we_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> stk_we_o);

   assert_pop_addr_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!push_i && (pop_i || pop_ret_i) && !trap_enter_i && !user_mode_o)
         |-> (stk_addr_o == ptr_q[BANK_SUP] && !stk_we_o));

   assert_trap_bank_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (trap_enter_i && push_i) |-> stk_addr_o == ptr_q[BANK_SUP] - STEP_V);

endmodule

// File: tb/spbank_unit_tb.sv
`timescale 1ns/1ps
module spbank_unit_tb;

   localparam logic [15:0] TOS = 16'hFF00;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 0, pop_i = 0, pop_ret_i = 0, to_user_i = 0;
   logic        trap_enter_i = 0, trap_ret_i = 0, stat_ld_i = 0;
   logic [7:0]  stat_ld_data_i = '0;
   logic [15:0] stk_addr_o;
   logic        stk_we_o, user_mode_o, priv_viol_o;
   logic [7:0]  stat_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // reference state
   logic [15:0] m_sup, m_usr;
   logic [7:0]  m_stat, m_save;
   logic        m_viol;

   always #4 clk = ~clk;

   spbank_unit u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .pop_ret_i(pop_ret_i),
      .to_user_i(to_user_i), .trap_enter_i(trap_enter_i), .trap_ret_i(trap_ret_i),
      .stat_ld_i(stat_ld_i), .stat_ld_data_i(stat_ld_data_i), .stk_addr_o(stk_addr_o),
      .stk_we_o(stk_we_o), .user_mode_o(user_mode_o), .stat_o(stat_o),
      .priv_viol_o(priv_viol_o));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] exp_addr(input logic push, input logic trap_in);
      logic [15:0] p;
      p = (!trap_in && m_stat[7]) ? m_usr : m_sup;
      return push ? p - 16'd2 : p;
   endfunction

   // one cycle: check registered state, drive, check combinational outputs, advance model
   task automatic step(input string tag, input logic pu, input logic po, input logic pr,
                       input logic tu, input logic ti, input logic tr, input logic ld,
                       input logic [7:0] d);
      logic usr_sel;
      @(negedge clk);
      chk({tag, " R6/R7/R8 mode"}, user_mode_o, m_stat[7]);
      chk({tag, " R8/R9 status"}, stat_o, m_stat);
      chk({tag, " R9 violation"}, priv_viol_o, m_viol);
      push_i = pu; pop_i = po; pop_ret_i = pr; to_user_i = tu;
      trap_enter_i = ti; trap_ret_i = tr; stat_ld_i = ld; stat_ld_data_i = d;
      #1;
      chk({tag, " R2/R3/R4/R5/R10 addr"}, stk_addr_o, exp_addr(pu, ti));
      chk({tag, " R4/R5 we"}, stk_we_o, pu);
      usr_sel = !ti && m_stat[7];
      if (pu || po || pr) begin
         if (usr_sel) m_usr = pu ? m_usr - 16'd2 : m_usr + 16'd2;
         else         m_sup = pu ? m_sup - 16'd2 : m_sup + 16'd2;
      end
      m_viol = 1'b0;
      if (ti) begin
         m_save = m_stat; m_stat[7] = 1'b0;
      end else if (tr) begin
         m_stat = m_save;
      end else if (tu) begin
         m_stat[7] = 1'b1;
      end else if (ld) begin
         if (m_stat[7]) m_viol = 1'b1;
         else           m_stat = {m_stat[7], d[6:0]};
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      m_sup = TOS; m_usr = TOS; m_stat = '0; m_save = '0; m_viol = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset values
      chk("R1 addr", stk_addr_o, TOS);
      chk("R1 we", stk_we_o, 0);
      chk("R1 mode", user_mode_o, 0);
      chk("R1 stat", stat_o, 0);
      chk("R1 viol", priv_viol_o, 0);
      rst_n = 1'b1;

      // directed corner cases
      step("R2 sup push",       1,0,0, 0,0,0, 0, 8'h00);
      step("R5 sup pop",        0,1,0, 0,0,0, 0, 8'h00);
      step("R6 sup load no U",  0,0,0, 0,0,0, 1, 8'hFF);
      step("R6 to user",        0,0,0, 1,0,0, 0, 8'h00);
      step("R3 usr push",       1,0,0, 0,0,0, 0, 8'h00);
      step("R3 usr push2",      1,0,0, 0,0,0, 0, 8'h00);
      step("R9 usr load",       0,0,0, 0,0,0, 1, 8'h00);
      step("R10 idle",          0,0,0, 0,0,0, 0, 8'h00);
      step("R7 trap+push",      1,0,0, 0,1,0, 0, 8'h00);
      step("R7 in handler",     1,0,0, 0,0,0, 0, 8'h00);
      step("R5 handler popret", 0,0,1, 0,0,0, 0, 8'h00);
      step("R8 trap return",    0,0,0, 0,0,1, 0, 8'h00);
      step("R11 all events",    1,1,1, 1,1,1, 1, 8'h55);
      step("R11 ret over jump", 0,1,0, 1,0,1, 1, 8'h00);
      step("R11 jump over load",0,0,0, 1,0,0, 1, 8'h7F);
      step("R9 refused again",  0,0,0, 0,0,0, 1, 8'h01);
      step("R10 idle2",         0,0,0, 0,0,0, 0, 8'h00);

      // constrained random mix
      for (int i = 0; i < 4000; i++) begin
         step("RND R11",
              ($urandom % 6) == 0, ($urandom % 7) == 0, ($urandom % 11) == 0,
              ($urandom % 13) == 0, ($urandom % 17) == 0, ($urandom % 15) == 0,
              ($urandom % 6) == 0, 8'($urandom));
      end
      step("end", 0,0,0, 0,0,0, 0, 8'h00);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule